// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog

This block is a watchdog timer that runs from the peripheral bus clock. Once switched on, a down-counter is loaded with a preset picked by a 4-bit range code and steps toward zero by one every clock cycle. Software must restart the count before it reaches zero. A restart happens only when a fixed key value is written.

If the count reaches zero, the block responds in one of two ways, chosen by a mode input:
- **Reset mode.** It issues a system reset pulse at once.
- **Interrupt-first mode.** It raises an interrupt on the first expiry. It issues the reset pulse only if that interrupt is still pending when the count expires a second time.

The reset pulse length is programmable. After any expiry the counter reloads its preset. Once enabled, the watchdog can only be stopped by the block reset. The preset base exponent is a parameter, 16 by default, so a reduced value can be used to shorten the timeouts.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, `irq` and `sys_rst` are 0 and `count` is 0. While `en_req` has never been high, `count` stays 0 and no reset pulse or interrupt is produced.
- R2: Enabling works as follows:
  - A high `en_req` while disabled loads `count` with 2^(BASE_LOG2+`range_sel`)-1 at the next clock edge.
  - After that, `count` falls by one per cycle.
  - Any later load, from a restart or an expiry, uses the `range_sel` value present at that edge.
- R3: Once enabled, the watchdog stays enabled until `rst_n` is low. Dropping `en_req` has no effect on the count.
- R4: A `kick_wr` with `kick_data` equal to the key 8'h76 reloads the preset at the next edge. A `kick_wr` with any other value is ignored, and the count keeps falling.
- R5: With `resp_irq`=0 (reset mode), an edge that sees `count`=0 sets `sys_rst` high from the next cycle and reloads the preset at that same edge.
- R6: With `resp_irq`=1 (interrupt-first mode), the first edge that sees `count`=0 sets `irq` to 1 and reloads the preset. `sys_rst` stays 0.
- R7: In interrupt-first mode, an expiry while `irq` is 1 starts the reset pulse and clears `irq`.
- R8: An `irq_clr` while `irq` is 1 clears `irq` and reloads the preset. An `irq_clr` while `irq` is 0 is ignored.
- R9: The reset pulse holds `sys_rst` high for exactly 2^(`plen_sel`+1) cycles, where `plen_sel` is the value present at the expiry edge. This gives a range of 2 to 256 cycles.
- R10: A key restart at the same edge where `count` is 0 takes priority over the expiry: the preset is reloaded, and neither `irq` nor `sys_rst` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low block reset |
| en_req | input | 1 | Enable request, sticky once accepted |
| resp_irq | input | 1 | 0: reset on expiry, 1: interrupt first |
| range_sel | input | 4 | Timeout range code |
| plen_sel | input | 3 | Reset pulse length code |
| kick_wr | input | 1 | Restart write strobe |
| kick_data | input | 8 | Restart write value |
| irq_clr | input | 1 | Interrupt clear strobe |
| irq | output | 1 | Pending timeout interrupt |
| sys_rst | output | 1 | System reset pulse |
| count | output | 32 | Current counter value |

## Verification
The escalation path is exercised in both modes with the same range code:
- Reset mode must pulse on the first expiry.
- Interrupt-first mode must stay quiet until the second expiry.

An interrupt clear in the middle of a period shows the difference between a reload caused by a clear and continued escalation. A clear while idle shows that the clear has no effect when nothing is pending.

Restarts are tried with a wrong key, with the right key in mid-count, and with the right key exactly at zero. These separate an ignored write, a reload, and the priority of a restart over an expiry.

Reset pulses of 2, 16 and 256 cycles are measured. This exposes an off-by-one error in the length decode or in the pulse counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    RESP_RESET = 1'b0,
    RESP_IRQ   = 1'b1
  } resp_e;

  // Number of ones in the preset for a range code.
  function automatic int unsigned preset_ones(int unsigned base, int unsigned code);
    return base + code;
  endfunction

  // Reset pulse length in cycles for a length code.
  function automatic int unsigned pulse_cycles(int unsigned code);
    return 1 << (code + 1);
  endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W     = 32,
  parameter int RANGE_W   = 4,
  parameter int BASE_LOG2 = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [RANGE_W-1:0] range_sel,
  output logic [CNT_W-1:0]   cnt,
  output logic               expire
);
  import wdt_pkg::*;

  localparam int MAX_ONES = BASE_LOG2 + (1 << RANGE_W) - 1;

  logic [CNT_W-1:0] preset;

  always_comb begin
    preset = {CNT_W{1'b1}} >> (CNT_W - preset_ones(BASE_LOG2, 32'(range_sel)));
  end

  assign expire = run && (cnt == '0) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || expire) begin
      cnt <= preset;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  initial begin
    if (MAX_ONES > CNT_W) $display("wdt_counter: preset wider than counter");
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !restart && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  // R10
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt == $past(preset));

endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expire,
  input  wdt_pkg::resp_e resp,
  input  logic          irq_clr,
  output logic          irq,
  output logic          fire,
  output logic          clr_ok
);
  import wdt_pkg::*;

  assign clr_ok = irq_clr && irq;
  assign fire   = expire && (resp == RESP_RESET || irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (fire) begin
      irq <= 1'b0;
    end else if (expire) begin
      irq <= 1'b1;
    end else if (clr_ok) begin
      irq <= 1'b0;
    end
  end

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire) && $past(resp) == RESP_IRQ);

  // R7
  second_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && resp == RESP_IRQ |-> irq);

  // R8
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> !irq);

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SEL_W-1:0] len_sel,
  output logic             rst_o
);
  import wdt_pkg::*;

  localparam int LEFT_W = (1 << SEL_W) + 1;

  logic [LEFT_W-1:0] left;
  logic [LEFT_W-1:0] len;

  always_comb begin
    len = LEFT_W'(pulse_cycles(32'(len_sel)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (fire) begin
      left <= len;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign rst_o = (left != '0);

  // R9
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rst_o);

  // R9
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> !$past(fire) && $past(left) == 1);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int          CNT_W     = 32,
  parameter int          RANGE_W   = 4,
  parameter int          SEL_W     = 3,
  parameter int          KEY_W     = 8,
  parameter int          BASE_LOG2 = 16,
  parameter logic [7:0]  KICK_KEY  = 8'h76
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_req,
  input  logic               resp_irq,
  input  logic [RANGE_W-1:0] range_sel,
  input  logic [SEL_W-1:0]   plen_sel,
  input  logic               kick_wr,
  input  logic [KEY_W-1:0]   kick_data,
  input  logic               irq_clr,
  output logic               irq,
  output logic               sys_rst,
  output logic [CNT_W-1:0]   count
);
  import wdt_pkg::*;

  logic  enabled;
  logic  start_evt;
  logic  kick_ok;
  logic  clr_ok;
  logic  restart_evt;
  logic  expire_evt;
  logic  fire_evt;
  resp_e resp;

  assign resp        = resp_e'(resp_irq);
  assign start_evt   = en_req && !enabled;
  assign kick_ok     = enabled && kick_wr && (kick_data == KEY_W'(KICK_KEY));
  assign restart_evt = start_evt || kick_ok || clr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
    end else if (start_evt) begin
      enabled <= 1'b1;
    end
  end

  wdt_counter #(
    .CNT_W    (CNT_W),
    .RANGE_W  (RANGE_W),
    .BASE_LOG2(BASE_LOG2)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enabled),
    .restart  (restart_evt),
    .range_sel(range_sel),
    .cnt      (count),
    .expire   (expire_evt)
  );

  wdt_escalate u_escalate (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire_evt),
    .resp   (resp),
    .irq_clr(irq_clr),
    .irq    (irq),
    .fire   (fire_evt),
    .clr_ok (clr_ok)
  );

  wdt_pulse #(
    .SEL_W(SEL_W)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire_evt),
    .len_sel(plen_sel),
    .rst_o  (sys_rst)
  );

  // R3
  sticky_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |=> enabled);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !irq && !sys_rst && count == '0);

  // R5
  reset_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt && resp == RESP_RESET |=> sys_rst && !irq);

endmodule

// File: tb/wdt_two_stage_test.sv
`timescale 1ns/1ps
module wdt_two_stage_test;

  localparam int BASE = 4;
  localparam logic [7:0] KEY = 8'h76;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_req = 1'b0;
  logic        resp_irq = 1'b0;
  logic [3:0]  range_sel = 4'd0;
  logic [2:0]  plen_sel = 3'd0;
  logic        kick_wr = 1'b0;
  logic [7:0]  kick_data = 8'h00;
  logic        irq_clr = 1'b0;
  logic        irq;
  logic        sys_rst;
  logic [31:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_two_stage #(.BASE_LOG2(BASE), .KICK_KEY(KEY)) uut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .resp_irq(resp_irq),
    .range_sel(range_sel), .plen_sel(plen_sel), .kick_wr(kick_wr),
    .kick_data(kick_data), .irq_clr(irq_clr), .irq(irq),
    .sys_rst(sys_rst), .count(count)
  );

  function automatic int unsigned exp_preset(int unsigned r);
    return (32'd1 << (BASE + r)) - 1;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en_req = 1'b0; resp_irq = 1'b0; kick_wr = 1'b0;
    irq_clr = 1'b0; range_sel = 4'd0; plen_sel = 3'd0;
    tick(3);
    rst_n = 1'b1;
  endtask

  // Enables at the current negedge; returns at the negedge where count == preset.
  task automatic enable(bit mode, int r, int p);
    en_req = 1'b1; resp_irq = mode; range_sel = 4'(r); plen_sel = 3'(p);
    tick(1);
    en_req = 1'b0;
  endtask

  task automatic kick(logic [7:0] v);
    kick_wr = 1'b1; kick_data = v;
    tick(1);
    kick_wr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    tick(1);
    check("R1 irq", irq, 0);
    check("R1 sys_rst", sys_rst, 0);
    check("R1 count", count, 0);
    tick(40);
    check("R1 idle count", count, 0);
    check("R1 idle sys_rst", sys_rst, 0);
  endtask

  task automatic t_reset_mode();
    do_reset();
    enable(1'b0, 0, 0);
    check("R2 preset r0", count, exp_preset(0));
    tick(5);
    check("R3 counting after en_req low", count, exp_preset(0) - 5);
    tick(10);
    check("R2 reaches zero", count, 0);
    check("R5 no early reset", sys_rst, 0);
    tick(1);
    check("R5 reset pulse", sys_rst, 1);
    check("R5 reload", count, exp_preset(0));
    check("R5 no irq", irq, 0);
    tick(1);
    check("R9 len2 second cycle", sys_rst, 1);
    tick(1);
    check("R9 len2 ends", sys_rst, 0);
  endtask

  task automatic measure_pulse(int r, int p, int exp_len);
    int len = 0;
    int guard = 0;
    do_reset();
    enable(1'b0, r, p);
    check("R2 preset", count, exp_preset(r));
    while (!sys_rst && guard < 5000) begin tick(1); guard++; end
    check("R5 reload at pulse start", count, exp_preset(r));
    while (sys_rst && len < 1000) begin tick(1); len++; end
    check("R9 pulse length", len, exp_len);
  endtask

  task automatic t_kick();
    do_reset();
    enable(1'b0, 1, 0);
    tick(10);
    check("R2 r1 count", count, exp_preset(1) - 10);
    kick(8'h75);
    check("R4 wrong key ignored", count, exp_preset(1) - 11);
    kick(KEY);
    check("R4 key reload", count, exp_preset(1));
    range_sel = 4'd2;
    tick(3);
    kick(KEY);
    check("R2 reload uses new range", count, exp_preset(2));
  endtask

  task automatic t_irq_mode();
    do_reset();
    enable(1'b1, 0, 1);
    tick(16);
    check("R6 irq set", irq, 1);
    check("R6 no reset", sys_rst, 0);
    check("R6 reload", count, exp_preset(0));
    tick(16);
    check("R7 reset on second expiry", sys_rst, 1);
    check("R7 irq cleared", irq, 0);
  endtask

  task automatic t_irq_clear();
    do_reset();
    enable(1'b1, 0, 0);
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
    check("R8 clear while idle ignored", count, exp_preset(0) - 1);
    tick(15);
    check("R6 irq", irq, 1);
    tick(3);
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
    check("R8 irq cleared", irq, 0);
    check("R8 clear reloads", count, exp_preset(0));
    tick(16);
    check("R8 fresh first stage", irq, 1);
    check("R8 no reset after clear", sys_rst, 0);
  endtask

  task automatic t_priority();
    do_reset();
    enable(1'b0, 0, 0);
    tick(15);
    check("R10 at zero", count, 0);
    kick(KEY);
    check("R10 reload", count, exp_preset(0));
    check("R10 no reset", sys_rst, 0);
    check("R10 no irq", irq, 0);
  endtask

  initial begin
    t_reset_state();
    t_reset_mode();
    measure_pulse(3, 3, 16);
    measure_pulse(5, 7, 256);
    t_kick();
    t_irq_mode();
    t_irq_clear();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule